// File: doc/BRIEF.md
# Dual-Clock Gray-Pointer FIFO with Registered Flags

This block passes words from a producer clock domain to a consumer clock domain. The producer presents a word with a write enable. The consumer pulls words with a read enable and gets them back from a register. Each side has its own address counter, and each counter advances in Gray code. The two counters are compared bit by bit to decide whether the queue is empty or full. That comparison is an AND of per-bit equalities, and only one pointer bit moves per step, so it cannot flicker true while the counters are far apart.

The design leaves one storage slot unused rather than keeping a direction bit. With an address of A bits, the queue holds 2^A-1 words. It is empty when both counters hold the same value. It is full when one more write would make the write counter equal the read counter.

Each flag is a flip-flop in the domain that has to stop. The full flag is clocked by the write clock and the empty flag by the read clock. Each flag is loaded from the pointer value that this cycle's transfer will produce, so it turns on at the very edge of the transfer that fills or drains the queue. A flag is cleared by activity in the other domain, and it may stay on one edge longer than strictly needed.

Top module: `gray_async_fifo`

## Requirements
- R1: A synchronous active-high reset in each domain clears that domain's pointer. After reset, `rd_empty` is 1, `wr_full` is 0 and `rd_data` is 0, and the next word written is the next word read.
- R2: Words are read out in the order they were written, with their values unchanged.
- R3: Starting from empty with no reads, `wr_full` stays 0 through the first 2^A-2 accepted writes. It becomes 1 right after the write clock edge that accepts write number 2^A-1.
- R4: A write request while `wr_full` is 1 is dropped. The write pointer does not move, no stored word changes, and `wr_full` stays 1.
- R5: `rd_empty` becomes 1 right after the read clock edge that accepts the read of the last stored word.
- R6: A read request while `rd_empty` is 1 is dropped. The read pointer does not move and `rd_data` keeps its value.
- R7: A flag is cleared only by the opposite domain. `rd_empty` falls no earlier than one read edge after the write edge that stored a word. `wr_full` falls one write edge after the read edge that freed a slot. Neither flag is 0 while its condition is still true.
- R8: `rd_data` is a register. It changes only on a read clock edge that accepts a read.
- R9: Both pointers step in Gray code, changing one bit per accepted transfer. Ordering is kept when the pointers wrap past address 2^A-1 back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Write-domain synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | Registered full flag (write clock) |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst | input | 1 | Read-domain synchronous reset, active high |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered read word |
| rd_empty | output | 1 | Registered empty flag (read clock) |

## Verification
The bench builds the FIFO with DATA_W=8 and ADDR_W=3, so the queue holds seven words. This small depth brings the full boundary, a write dropped while full, and a pointer wrap past address 7 within a few dozen cycles. The same counts show the one-edge-late clearing of both flags and the same-edge setting of each flag. Simultaneous reads and writes, reads dropped while empty, and a reset with words still stored are also exercised at this depth.

// File: rtl/gray_fifo_pkg.sv
package gray_fifo_pkg;

    localparam int DEF_DATA_W = 8;
    localparam int DEF_ADDR_W = 9;

    // Selects which flag a comparator instance produces.
    typedef enum logic {
        FLAG_IS_EMPTY = 1'b0,
        FLAG_IS_FULL  = 1'b1
    } flag_kind_e;

    // Value a flag of the given kind takes under reset.
    function automatic logic flag_reset_value(input flag_kind_e kind);
        return (kind == FLAG_IS_EMPTY);
    endfunction

endpackage

// File: rtl/gray_fifo_ctr.sv
module gray_fifo_ctr
    import gray_fifo_pkg::*;
#(
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int LOOKAHEAD = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc,
    output logic [ADDR_W-1:0] bin,
    output logic [ADDR_W-1:0] gray,
    output logic [ADDR_W-1:0] look_gray
);

    function automatic logic [ADDR_W-1:0] to_gray(input logic [ADDR_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    logic [ADDR_W-1:0] bin_q;
    logic [ADDR_W-1:0] gray_q;
    logic [ADDR_W-1:0] bin_nxt;
    logic [ADDR_W-1:0] bin_look;

    assign bin_nxt = bin_q + ADDR_W'(inc);

    // The parameter picks which future pointer value is exported for the flag compare.
    generate
        if (LOOKAHEAD == 0) begin : g_look_now
            assign bin_look = bin_nxt;
        end else begin : g_look_ahead
            assign bin_look = bin_nxt + ADDR_W'(LOOKAHEAD);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else begin
            bin_q  <= bin_nxt;
            gray_q <= to_gray(bin_nxt);
        end
    end

    assign bin       = bin_q;
    assign gray      = gray_q;
    assign look_gray = to_gray(bin_look);

    // R9: the exported Gray pointer never moves more than one bit per edge
    a_r9_gray_single_step: assert property (@(posedge clk) disable iff (rst)
        $countones(gray_q ^ $past(gray_q)) <= 1);

endmodule

// File: rtl/gray_fifo_mem.sv
module gray_fifo_mem
    import gray_fifo_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              rrst,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge wclk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    always_ff @(posedge rclk) begin
        if (rrst) begin
            rdata_q <= '0;
        end else if (re) begin
            rdata_q <= store[raddr];
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/gray_fifo_flag.sv
module gray_fifo_flag
    import gray_fifo_pkg::*;
#(
    parameter int         ADDR_W = DEF_ADDR_W,
    parameter flag_kind_e KIND   = FLAG_IS_EMPTY
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] local_ptr,
    input  logic [ADDR_W-1:0] far_ptr,
    output logic              flag
);

    localparam logic RST_VAL = flag_reset_value(KIND);

    logic match;
    logic flag_q;

    // Identity compare: AND over per-bit XNOR
    assign match = &(~(local_ptr ^ far_ptr));

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= RST_VAL;
        end else begin
            flag_q <= match;
        end
    end

    assign flag = flag_q;

endmodule

// File: rtl/gray_async_fifo.sv
module gray_async_fifo
    import gray_fifo_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty
);

    logic              wr_take;
    logic              rd_take;
    logic [ADDR_W-1:0] wr_bin;
    logic [ADDR_W-1:0] wr_gray;
    logic [ADDR_W-1:0] wr_look;
    logic [ADDR_W-1:0] rd_bin;
    logic [ADDR_W-1:0] rd_gray;
    logic [ADDR_W-1:0] rd_look;

    assign wr_take = wr_en & ~wr_full;
    assign rd_take = rd_en & ~rd_empty;

    // Write pointer; lookahead of one step gives the "about to wrap onto reader" test
    gray_fifo_ctr #(.ADDR_W(ADDR_W), .LOOKAHEAD(1)) u_wr_ctr (
        .clk       (wr_clk),
        .rst       (wr_rst),
        .inc       (wr_take),
        .bin       (wr_bin),
        .gray      (wr_gray),
        .look_gray (wr_look)
    );

    // Read pointer; lookahead zero gives the post-read pointer
    gray_fifo_ctr #(.ADDR_W(ADDR_W), .LOOKAHEAD(0)) u_rd_ctr (
        .clk       (rd_clk),
        .rst       (rd_rst),
        .inc       (rd_take),
        .bin       (rd_bin),
        .gray      (rd_gray),
        .look_gray (rd_look)
    );

    gray_fifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .wclk  (wr_clk),
        .we    (wr_take),
        .waddr (wr_bin),
        .wdata (wr_data),
        .rclk  (rd_clk),
        .rrst  (rd_rst),
        .re    (rd_take),
        .raddr (rd_bin),
        .rdata (rd_data)
    );

    gray_fifo_flag #(.ADDR_W(ADDR_W), .KIND(FLAG_IS_FULL)) u_full (
        .clk       (wr_clk),
        .rst       (wr_rst),
        .local_ptr (wr_look),
        .far_ptr   (rd_gray),
        .flag      (wr_full)
    );

    gray_fifo_flag #(.ADDR_W(ADDR_W), .KIND(FLAG_IS_EMPTY)) u_empty (
        .clk       (rd_clk),
        .rst       (rd_rst),
        .local_ptr (rd_look),
        .far_ptr   (wr_gray),
        .flag      (rd_empty)
    );

    // R1: reset leaves each flag in its idle value
    a_r1_full_reset: assert property (@(posedge wr_clk)
        wr_rst |=> !wr_full);
    a_r1_empty_reset: assert property (@(posedge rd_clk)
        rd_rst |=> rd_empty);

    // R4: a write offered while full leaves the write pointer in place
    a_r4_no_overflow: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_en && wr_full) |=> $stable(wr_gray));

    // R6: a read offered while empty leaves the read pointer in place
    a_r6_no_underflow: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_en && rd_empty) |=> $stable(rd_gray));

    // R8: read word only moves on an accepted read
    a_r8_rdata_hold: assert property (@(posedge rd_clk) disable iff (rd_rst)
        !(rd_en && !rd_empty) |=> $stable(rd_data));

endmodule

// File: tb/test_gray_async_fifo.sv
module test_gray_async_fifo;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 3;
    localparam int CAP        = (1 << ADDR_W) - 1;
    localparam int N_VEC      = 7;

    // vector: [20] wr, [19] rd, [18:11] wdata, [10] check rd_data,
    //         [9:2] expected rd_data, [1] expected empty, [0] expected full
    localparam logic [20:0] VEC [N_VEC] = '{
        {1'b1, 1'b0, 8'hA1, 1'b0, 8'h00, 1'b1, 1'b0},
        {1'b1, 1'b0, 8'hA2, 1'b0, 8'h00, 1'b0, 1'b0},
        {1'b0, 1'b1, 8'h00, 1'b1, 8'hA1, 1'b0, 1'b0},
        {1'b1, 1'b1, 8'hA3, 1'b1, 8'hA2, 1'b1, 1'b0},
        {1'b0, 1'b0, 8'h00, 1'b1, 8'hA2, 1'b0, 1'b0},
        {1'b0, 1'b1, 8'h00, 1'b1, 8'hA3, 1'b1, 1'b0},
        {1'b0, 1'b1, 8'h00, 1'b1, 8'hA3, 1'b1, 1'b0}
    };

    logic              wr_clk = 1'b0;
    logic              rd_clk = 1'b0;
    logic              wr_rst = 1'b1;
    logic              rd_rst = 1'b1;
    logic              wr_en  = 1'b0;
    logic              rd_en  = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic              wr_full;
    logic              rd_empty;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always begin
        #(CLK_PERIOD / 2);
        wr_clk = ~wr_clk;
        rd_clk = ~rd_clk;
    end

    gray_async_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_gray_async_fifo (
        .wr_clk   (wr_clk),
        .wr_rst   (wr_rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .wr_full  (wr_full),
        .rd_clk   (rd_clk),
        .rd_rst   (rd_rst),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .rd_empty (rd_empty)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Drive at a falling edge, pass one rising edge, return at the next falling edge.
    task automatic step(input logic w, input logic [DATA_W-1:0] d, input logic r);
        wr_en   = w;
        wr_data = d;
        rd_en   = r;
        @(negedge wr_clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
    endtask

    task automatic do_reset();
        wr_rst = 1'b1;
        rd_rst = 1'b1;
        @(negedge wr_clk);
        @(negedge wr_clk);
        wr_rst = 1'b0;
        rd_rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        @(negedge wr_clk);
        do_reset();
        check("R1", "empty after reset", int'(rd_empty), 1);
        check("R1", "full after reset", int'(wr_full), 0);
        check("R1", "rd_data after reset", int'(rd_data), 0);

        // Vector walk: late clear of empty, simultaneous read/write, drain, dropped read
        for (int i = 0; i < N_VEC; i++) begin
            step(VEC[i][20], VEC[i][18:11], VEC[i][19]);
            if (VEC[i][10]) begin
                check("R2 R6 R8", $sformatf("vector %0d rd_data", i), int'(rd_data), int'(VEC[i][9:2]));
            end
            check("R5 R7", $sformatf("vector %0d empty", i), int'(rd_empty), int'(VEC[i][1]));
            check("R3", $sformatf("vector %0d full", i), int'(wr_full), int'(VEC[i][0]));
        end

        // Fill to capacity; pointers start at 3 so this wraps past address 7
        for (int i = 0; i < CAP; i++) begin
            step(1'b1, DATA_W'(8'h10 + i), 1'b0);
            if (i == CAP - 2) check("R3", "full before last slot", int'(wr_full), 0);
            if (i == CAP - 1) check("R3", "full at capacity", int'(wr_full), 1);
        end

        step(1'b1, 8'hEE, 1'b0);
        check("R4", "full after dropped write", int'(wr_full), 1);

        step(1'b0, '0, 1'b1);
        check("R2", "first word out", int'(rd_data), 8'h10);
        check("R7", "full still set one edge after read", int'(wr_full), 1);

        step(1'b0, '0, 1'b0);
        check("R7", "full cleared one edge later", int'(wr_full), 0);
        check("R8", "rd_data held when idle", int'(rd_data), 8'h10);

        for (int i = 1; i < CAP; i++) begin
            step(1'b0, '0, 1'b1);
            check("R2 R4 R9", $sformatf("drain word %0d", i), int'(rd_data), 8'h10 + i);
            if (i == CAP - 2) check("R5", "empty before last word", int'(rd_empty), 0);
            if (i == CAP - 1) check("R5", "empty on last read", int'(rd_empty), 1);
        end

        step(1'b0, '0, 1'b1);
        check("R6", "rd_data after read while empty", int'(rd_data), 8'h16);
        check("R6", "empty stays after dropped read", int'(rd_empty), 1);

        // Reset with words stored
        step(1'b1, 8'h55, 1'b0);
        step(1'b1, 8'h66, 1'b0);
        do_reset();
        check("R1", "empty after reset with data", int'(rd_empty), 1);
        check("R1", "full after reset with data", int'(wr_full), 0);

        step(1'b1, 8'h77, 1'b0);
        check("R7", "empty still set right after write", int'(rd_empty), 1);
        step(1'b0, '0, 1'b0);
        check("R7", "empty cleared one edge later", int'(rd_empty), 0);
        step(1'b0, '0, 1'b1);
        check("R1", "first word after reset", int'(rd_data), 8'h77);
        check("R5", "empty after single word drained", int'(rd_empty), 1);

        finish_run();
    end

endmodule